// File: doc/BRIEF.md
# Programmable Reed-Solomon Stream Encoder

This block is a systematic Reed-Solomon encoder over GF(2^8). It accepts one 8-bit symbol on every clock. Data symbols pass straight through to the output. Once the data portion of a block ends, the computed check symbols follow on the same bus. The number of check symbols, r, is an even value from 0 to 20. It is programmed as a half-count word. That word is sampled while the block is held in reset and again at the start of every block, so the code rate can change between blocks while the stream keeps running. A half-count of zero turns the block into a plain three-clock delay line.

Two enables frame each block. An input enable marks the data symbols; while it is low the generator takes in zero symbols, so that its contents shift out. An output-select enable chooses, at the head of the pipeline, between the incoming data and the top of the check-symbol register. The encoder therefore needs the input enable high for the k data symbols and both enables low for r clocks afterwards. Every output is three registers behind the input. A ready strobe repeats the input enable with the same delay. An output-off control zeroes the bus and lowers a drive flag without touching the encoding state.

Top module: `rs_stream_encoder`

## Requirements
- R1: After k data symbols m0..m(k-1) (m0 is the highest-degree coefficient), the r check symbols are the remainder of m(x)·x^r divided by g(x) = (x+α^0)(x+α^1)…(x+α^(r-1)). Here α = 0x02 and field products reduce by 0x11D. The remainder appears highest-degree coefficient first, on the r clocks with input enable and output-select both low.
- R2: r is twice the sampled half-count. A half-count above 10 counts as 10, giving r = 20.
- R3: The half-count is sampled on every clock where the synchronized reset is low and input enable is low. It is sampled again on the clock where input enable rises (block start), and that value sets r for the block that starts there.
- R4: A block start discards whatever the check-symbol generator still holds, even when the previous block's check symbols were only partly emitted.
- R5: While input enable is low, zero symbols enter the generator and its contents move one place toward the output. Once all r check symbols have been emitted, further clocks with output-select low put 0x00 on the output.
- R6: A symbol taken in while output-select is high reaches the output unchanged. A symbol taken in while it is low is replaced by the current check symbol.
- R7: A symbol captured at a rising edge is on dout after the second following edge, so a downstream register captures it at the third edge.
- R8: rdy equals in_en delayed by three clocks.
- R9: While out_off is high, dout is 0x00 and drive_en is 0 in the same cycle. Neither the encoding state nor the pipeline is disturbed.
- R10: With r = 0, no check symbols are produced. Output-select low gives 0x00, and data passes with the three-clock delay.
- R11: During reset, dout and rdy are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 8 | Incoming symbol |
| in_en | input | 1 | High for data symbols; low feeds zeros to the generator |
| out_sel | input | 1 | High selects data, low selects check symbols |
| half_cnt | input | 4 | Half the number of check symbols (unsigned, bit 0 least significant) |
| out_off | input | 1 | Forces dout to zero and drops drive_en |
| dout | output | 8 | Outgoing symbol, three clocks behind din |
| drive_en | output | 1 | High when the bus should be driven |
| rdy | output | 1 | in_en delayed by three clocks |

## Verification
Output-off and check-symbol emission can fall in the same cycles. The output-off control acts on the bus combinationally, while the generator keeps shifting out behind it. The bench raises out_off on the first check-symbol clock and on randomly chosen clocks across many blocks. It then expects zero on those clocks and the exact reference remainder on the clocks around them. A block start can also coincide with a rate change and with leftover, half-emitted check symbols. A directed case cuts the emission short and then starts a block with a new half-count, and the new block's check symbols are compared with a fresh long division.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

  localparam int SYM_W = 8;
  localparam logic [SYM_W-1:0] FIELD_LOW = 8'h1D;  // x^8 folded into x^4+x^3+x^2+1

  typedef logic [SYM_W-1:0] sym_t;

  // multiply by alpha (0x02)
  function automatic sym_t gf_xtime(input sym_t a);
    return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? FIELD_LOW : '0);
  endfunction

  // general field product, shift-and-add
  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

endpackage

// File: rtl/rs_cfg_ctrl.sv
module rs_cfg_ctrl
  import rs_enc_pkg::*;
#(
  parameter int MAX_HALF = 10,
  parameter int CFG_W    = 4,
  localparam int MAXR    = 2 * MAX_HALF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_en,
  input  logic [CFG_W-1:0]     half_cnt,
  output logic                 rst_sync_n,
  output logic                 blk_start,
  output logic [CFG_W-1:0]     cfg_half,
  output logic [MAXR*SYM_W-1:0] coefs
);

  // generator coefficients g0..g(n-1), placed in the top n tap slots
  function automatic logic [MAXR*SYM_W-1:0] gen_aligned(input int nroots);
    sym_t g [0:MAXR];
    sym_t root;
    logic [MAXR*SYM_W-1:0] res;
    for (int i = 0; i <= MAXR; i++) g[i] = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int j = 0; j < MAXR; j++) begin
      if (j < nroots) begin
        for (int i = MAXR; i > 0; i--) g[i] = g[i-1] ^ gf_mul(g[i], root);
        g[0] = gf_mul(g[0], root);
        root = gf_xtime(root);
      end
    end
    res = '0;
    for (int i = 0; i < MAXR; i++) begin
      if (i < nroots) res[(MAXR - nroots + i)*SYM_W +: SYM_W] = g[i];
    end
    return res;
  endfunction

  function automatic logic [CFG_W-1:0] clamp_half(input logic [CFG_W-1:0] v);
    return (v > CFG_W'(MAX_HALF)) ? CFG_W'(MAX_HALF) : v;
  endfunction

  logic [1:0]             sync_q;
  logic                   in_en_q;
  logic [CFG_W-1:0]       cfg_q;
  logic [CFG_W-1:0]       cfg_d;
  logic                   cfg_load;
  logic [CFG_W-1:0]       half_sel;
  logic [MAXR*SYM_W-1:0]  coef_tab [0:MAX_HALF];

  // reset: asserted at once, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) in_en_q <= 1'b0;
    else             in_en_q <= in_en;
  end

  always_comb begin
    blk_start = in_en & ~in_en_q & rst_sync_n;
    cfg_load  = (~rst_sync_n & ~in_en) | blk_start;
    cfg_d     = clamp_half(half_cnt);
    half_sel  = blk_start ? cfg_d : cfg_q;
  end

  // configuration holder: loaded during reset, so no reset of its own
  always_ff @(posedge clk) begin
    if (cfg_load) cfg_q <= cfg_d;
  end
  assign cfg_half = cfg_q;

  for (genvar k = 0; k <= MAX_HALF; k++) begin : g_tab
    localparam logic [MAXR*SYM_W-1:0] GK = gen_aligned(2 * k);
    assign coef_tab[k] = GK;
  end

  assign coefs = coef_tab[half_sel];

endmodule

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
  import rs_enc_pkg::*;
#(
  parameter int MAXR = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_en,
  input  logic                  blk_start,
  input  sym_t                  din,
  input  logic [MAXR*SYM_W-1:0] coefs,
  output sym_t                  par_top
);

  sym_t par_q [MAXR];
  sym_t par_d [MAXR];
  sym_t fb;

  always_comb begin
    if (!in_en)         fb = '0;
    else if (blk_start) fb = din;
    else                fb = din ^ par_q[MAXR-1];
  end

  for (genvar i = 0; i < MAXR; i++) begin : g_tap
    sym_t prev;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = blk_start ? '0 : par_q[i-1];
    end
    always_comb par_d[i] = prev ^ gf_mul(coefs[i*SYM_W +: SYM_W], fb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MAXR; i++) par_q[i] <= '0;
    end else begin
      for (int i = 0; i < MAXR; i++) par_q[i] <= par_d[i];
    end
  end

  assign par_top = par_q[MAXR-1];

endmodule

// File: rtl/rs_out_pipe.sv
module rs_out_pipe
  import rs_enc_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_en,
  input  logic out_sel,
  input  sym_t din,
  input  sym_t par_top,
  input  logic out_off,
  output sym_t dout,
  output logic drive_en,
  output logic rdy
);

  sym_t dat_q [LAT];
  sym_t dat_d [LAT];
  logic en_q  [LAT];
  logic en_d  [LAT];

  always_comb begin
    dat_d[0] = out_sel ? din : par_top;
    en_d[0]  = in_en;
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_comb begin
      dat_d[s] = dat_q[s-1];
      en_d[s]  = en_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) begin
        dat_q[s] <= '0;
        en_q[s]  <= 1'b0;
      end
    end else begin
      for (int s = 0; s < LAT; s++) begin
        dat_q[s] <= dat_d[s];
        en_q[s]  <= en_d[s];
      end
    end
  end

  always_comb begin
    dout     = out_off ? '0 : dat_q[LAT-1];
    drive_en = ~out_off;
    rdy      = en_q[LAT-1];
  end

endmodule

// File: rtl/rs_stream_encoder.sv
module rs_stream_encoder
  import rs_enc_pkg::*;
#(
  parameter int MAX_HALF = 10,
  parameter int CFG_W    = 4,
  parameter int LAT      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       din,
  input  logic             in_en,
  input  logic             out_sel,
  input  logic [CFG_W-1:0] half_cnt,
  input  logic             out_off,
  output logic [7:0]       dout,
  output logic             drive_en,
  output logic             rdy
);

  localparam int MAXR = 2 * MAX_HALF;

  logic                  rst_sync_n;
  logic                  blk_start;
  logic [CFG_W-1:0]      cfg_half;
  logic [MAXR*SYM_W-1:0] coefs;
  sym_t                  par_top;

  rs_cfg_ctrl #(.MAX_HALF(MAX_HALF), .CFG_W(CFG_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_en      (in_en),
    .half_cnt   (half_cnt),
    .rst_sync_n (rst_sync_n),
    .blk_start  (blk_start),
    .cfg_half   (cfg_half),
    .coefs      (coefs)
  );

  rs_parity_lfsr #(.MAXR(MAXR)) u_lfsr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_en     (in_en),
    .blk_start (blk_start),
    .din       (din),
    .coefs     (coefs),
    .par_top   (par_top)
  );

  rs_out_pipe #(.LAT(LAT)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_en    (in_en),
    .out_sel  (out_sel),
    .din      (din),
    .par_top  (par_top),
    .out_off  (out_off),
    .dout     (dout),
    .drive_en (drive_en),
    .rdy      (rdy)
  );

endmodule

// File: rtl/rs_stream_encoder_chk.sv
module rs_stream_encoder_chk #(
  parameter int MAX_HALF = 10,
  parameter int CFG_W    = 4,
  parameter int LAT      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic [7:0]       din,
  input logic             in_en,
  input logic             out_sel,
  input logic             out_off,
  input logic [7:0]       dout,
  input logic             drive_en,
  input logic             rdy,
  input logic [CFG_W-1:0] cfg_half,
  input logic [7:0]       par_top
);

  localparam int CW = $clog2(LAT + 1) + 1;
  logic [CW-1:0] live_cnt;

  // edges since synchronized release, saturating at LAT
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       live_cnt <= '0;
    else if (!rst_sync_n)             live_cnt <= '0;
    else if (live_cnt != CW'(LAT))    live_cnt <= live_cnt + 1'b1;
  end

  assert_rdy_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == CW'(LAT)) |-> (rdy == $past(in_en, LAT)));

  assert_data_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == CW'(LAT) && !out_off && $past(out_sel, LAT)) |-> (dout == $past(din, LAT)));

  assert_output_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_off |-> (dout == 8'h00 && !drive_en));

  assert_cfg_clamped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_sync_n |-> (cfg_half <= CFG_W'(MAX_HALF)));

  assert_passthru_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_sync_n && cfg_half == '0) |-> (par_top == 8'h00));

endmodule

bind rs_stream_encoder rs_stream_encoder_chk #(
  .MAX_HALF (MAX_HALF),
  .CFG_W    (CFG_W),
  .LAT      (LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .din        (din),
  .in_en      (in_en),
  .out_sel    (out_sel),
  .out_off    (out_off),
  .dout       (dout),
  .drive_en   (drive_en),
  .rdy        (rdy),
  .cfg_half   (cfg_half),
  .par_top    (par_top)
);

// File: tb/rs_stream_encoder_tb.sv
module rs_stream_encoder_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] din;
  logic       in_en;
  logic       out_sel;
  logic [3:0] half_cnt;
  logic       out_off;
  logic [7:0] dout;
  logic       drive_en;
  logic       rdy;

  int checks = 0;
  int fails  = 0;

  rs_stream_encoder u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .in_en(in_en), .out_sel(out_sel),
    .half_cnt(half_cnt), .out_off(out_off), .dout(dout), .drive_en(drive_en), .rdy(rdy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // bench-side expectation pipeline, three deep
  logic [7:0] pe   [3];
  logic       pen  [3];
  string      ptg  [3];

  logic [7:0] msg  [0:299];
  logic [7:0] wrk  [0:299];
  logic [7:0] gp   [0:20];
  logic [7:0] par  [0:19];
  int         cur_half;
  bit         last_en;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  // remainder of msg(x)*x^r by the generator, by long division
  task automatic make_parity(input int k, input int r);
    logic [7:0] root;
    for (int i = 0; i <= 20; i++) gp[i] = 8'h00;
    gp[0] = 8'h01;
    root  = 8'h01;
    for (int j = 0; j < r; j++) begin
      for (int i = j + 1; i > 0; i--) gp[i] = gp[i-1] ^ gmul(gp[i], root);
      gp[0] = gmul(gp[0], root);
      root  = gmul(root, 8'h02);
    end
    for (int i = 0; i < k + r; i++) wrk[i] = (i < k) ? msg[i] : 8'h00;
    for (int j = 0; j < k; j++) begin
      logic [7:0] c = wrk[j];
      for (int i = 0; i <= r; i++) wrk[j+i] ^= gmul(c, gp[r-i]);
    end
    for (int i = 0; i < r; i++) par[i] = wrk[k+i];
  endtask

  task automatic step(input logic [7:0] d, input logic en, input logic sel,
                      input logic off, input logic [7:0] e, input string tg);
    @(negedge clk);
    din = d; in_en = en; out_sel = sel; out_off = off;
    #1;
    chk(off ? {"R9 off ", ptg[2]} : ptg[2], dout, off ? 8'h00 : pe[2]);
    chk("R9 drive_en", {7'd0, drive_en}, {7'd0, ~off});
    chk("R8 rdy", {7'd0, rdy}, {7'd0, pen[2]});
    pe[2] = pe[1];  pen[2] = pen[1];  ptg[2] = ptg[1];
    pe[1] = pe[0];  pen[1] = pen[0];  ptg[1] = ptg[0];
    pe[0] = e;      pen[0] = en;      ptg[0] = tg;
  endtask

  task automatic do_reset(input logic [3:0] h);
    @(negedge clk);
    rst_n = 1'b0; in_en = 1'b0; out_sel = 1'b0; out_off = 1'b0; din = 8'h00; half_cnt = h;
    repeat (5) @(negedge clk);
    chk("R11 reset dout", dout, 8'h00);
    chk("R11 reset rdy", {7'd0, rdy}, 8'h00);
    for (int s = 0; s < 3; s++) begin pe[s] = 8'h00; pen[s] = 1'b0; ptg[s] = "R11 idle"; end
    rst_n = 1'b1;
    cur_half = (h > 10) ? 10 : int'(h);
    last_en  = 1'b0;
    for (int s = 0; s < 5; s++) step(8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R5 idle");
  endtask

  // offmode: 0 none, 1 random, 2 on first check-symbol clock
  task automatic run_block(input int k, input int gap, input logic [3:0] h,
                           input int offmode, input string gtag);
    int r;
    if (!last_en) cur_half = (h > 10) ? 10 : int'(h);
    half_cnt = h;
    r = 2 * cur_half;
    for (int i = 0; i < k; i++) msg[i] = 8'($urandom);
    make_parity(k, r);
    for (int i = 0; i < k; i++) begin
      logic off = (offmode == 1) ? (($urandom % 5) == 0) : 1'b0;
      step(msg[i], 1'b1, 1'b1, off, msg[i], (r == 0) ? "R10 R6 R7 data" : "R6 R7 data");
    end
    for (int j = 0; j < gap; j++) begin
      logic off = (offmode == 1) ? (($urandom % 4) == 0) : ((offmode == 2) && j == 0);
      if (j < r) step(8'($urandom), 1'b0, 1'b0, off, par[j], gtag);
      else       step(8'($urandom), 1'b0, 1'b0, off, 8'h00, (r == 0) ? "R10 pass" : "R5 flushed");
    end
    last_en = (gap == 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    rst_n = 1'b1; in_en = 1'b0; out_sel = 1'b0; out_off = 1'b0; din = 8'h00; half_cnt = 4'd0;
    do_reset(4'd2);

    // R1 basic encoding, r=4
    run_block(16, 4, 4'd2, 0, "R1 parity");
    // R3 rate change at block start, r=10 then r=6
    run_block(20, 10, 4'd5, 0, "R3 R1 parity");
    run_block(9, 8, 4'd3, 0, "R3 R5 parity");
    // R2 clamp: 13 acts as 10, r=20
    run_block(30, 22, 4'd13, 0, "R2 clamp parity");
    // R4 truncated emission then new block
    run_block(12, 3, 4'd4, 0, "R4 partial");
    run_block(11, 8, 4'd4, 0, "R4 fresh parity");
    // R9 output-off on first check-symbol clock
    run_block(10, 6, 4'd3, 2, "R9 R1 parity");
    // R10 pass-through, continuous enable
    run_block(8, 0, 4'd0, 0, "R10 pass");
    run_block(8, 3, 4'd0, 0, "R10 pass");
    // single-symbol block, maximum parity
    run_block(1, 20, 4'd10, 0, "R1 short parity");

    for (int b = 0; b < 40; b++) begin
      int h  = $urandom % 13;
      int rr = 2 * ((h > 10) ? 10 : h);
      int k  = 1 + ($urandom % 40);
      int g  = rr + ($urandom % 3);
      run_block(k, g, 4'(h), ($urandom % 3 == 0) ? 1 : 0, "R1 random parity");
    end

    // reset again with a clamped value and encode
    do_reset(4'd15);
    run_block(25, 20, 4'd15, 0, "R2 R3 reset parity");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule